// File: doc/BRIEF.md
# Predicate Compare and Guard Unit

This block holds a file of single-bit condition flags (predicates) and updates it from compare requests. A request carries two 64-bit operands, a test code, a combine type, a qualifying-predicate index and two destination indices. The unit evaluates the test and writes up to two destination flags. It can write the outcome and its inverse, or it can merge the outcome with the values the flags already hold. A single request can therefore settle a chain of conditions.

The same file supplies guard bits to instruction issue. Each guard port takes a 6-bit predicate index and returns the flag it names, with no clock delay. A full snapshot of the file is also available as an output. Flag 0 is hard-wired true. The compare path also flags requests it rejects, so the caller can see that no write took place.

Top module: `pred_cmp_unit`

## Requirements
- R1: After reset, every flag reads 0 except flag 0, so the snapshot equals 64'h1.
- R2: Flag 0 always reads 1. A compare that names index 0 as a destination leaves it at 1.
- R3: Test codes are 0 eq, 1 ne, 2 signed lt, 3 signed le, 4 signed gt, 5 signed ge, 6 unsigned lt, 7 unsigned le, 8 unsigned gt, 9 unsigned ge, each computed as A op B. In normal type (combine code 0) with a true qualifying flag, the first destination takes the outcome and the second takes its inverse. The new values appear on the snapshot just after the clock edge that accepts the request.
- R4: Unconditional type (code 1) behaves like normal type when the qualifying flag is true. When the qualifying flag is false, it clears both destinations.
- R5: A normal, AND or OR request whose qualifying flag is false writes nothing.
- R6: AND type (code 2) clears both destinations when the outcome is false. It leaves them unchanged when the outcome is true.
- R7: OR type (code 3) sets both destinations when the outcome is true. It leaves them unchanged when the outcome is false.
- R8: When both destination indices are equal, `req_illegal` is high in the same cycle as the request and the file is unchanged.
- R9: A test code of 10 or above raises `req_illegal` and writes nothing.
- R10: Each guard port returns, combinationally, the current value of the flag its index selects. Index 0 returns 1.
- R11: Requests may arrive on consecutive cycles. Each request reads its qualifying flag from the file as the previous edge left it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Compare request present this cycle |
| req_opa | input | 64 | Operand A |
| req_opb | input | 64 | Operand B |
| req_test | input | 4 | Test code |
| req_ctype | input | 2 | Combine type: 0 normal, 1 unconditional, 2 AND, 3 OR |
| req_dst1 | input | 6 | First destination index |
| req_dst2 | input | 6 | Second destination index |
| req_qp | input | 6 | Qualifying-predicate index |
| req_illegal | output | 1 | Request rejected, no write |
| guard_idx | input | 12 | Two packed 6-bit guard indices |
| guard_bit | output | 2 | Guard values, one per port |
| pred_snapshot | output | 64 | Whole predicate file |

## Verification
`req_illegal` and the guard bits are combinational, so the bench checks them one time unit after it drives the inputs, before the next clock edge. A compare takes effect on the first rising edge after it is presented. For each request the driver pushes the expected snapshot into a queue. The monitor pops that entry and compares it two time units after the edge, well before the next input change at the falling edge. Back-to-back requests produce one queue entry per edge, so the order of the entries follows the clock.

// File: rtl/pred_cmp_pkg.sv
package pred_cmp_pkg;
  typedef enum logic [3:0] {
    TST_EQ  = 4'd0, TST_NE  = 4'd1,
    TST_LT  = 4'd2, TST_LE  = 4'd3, TST_GT  = 4'd4, TST_GE  = 4'd5,
    TST_LTU = 4'd6, TST_LEU = 4'd7, TST_GTU = 4'd8, TST_GEU = 4'd9
  } test_e;

  typedef enum logic [1:0] {
    CT_NORM = 2'd0, CT_UNC = 2'd1, CT_AND = 2'd2, CT_OR = 2'd3
  } ctype_e;

  typedef struct packed {
    logic en1;
    logic val1;
    logic en2;
    logic val2;
  } pwrite_s;
endpackage

// File: rtl/pred_cmp_eval.sv
module pred_cmp_eval #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [3:0]        test,
  output logic              result,
  output logic              code_ok
);
  import pred_cmp_pkg::*;

  logic eq, slt, ult;

  always_comb begin
    eq  = (opa == opb);
    slt = ($signed(opa) < $signed(opb));
    ult = (opa < opb);
    code_ok = 1'b1;
    unique case (test)
      TST_EQ:  result = eq;
      TST_NE:  result = !eq;
      TST_LT:  result = slt;
      TST_LE:  result = slt || eq;
      TST_GT:  result = !(slt || eq);
      TST_GE:  result = !slt;
      TST_LTU: result = ult;
      TST_LEU: result = ult || eq;
      TST_GTU: result = !(ult || eq);
      TST_GEU: result = !ult;
      default: begin
        result  = 1'b0;
        code_ok = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/pred_cmp_wb.sv
module pred_cmp_wb (
  input  logic                     go,
  input  logic [1:0]               ctype,
  input  logic                     qp_val,
  input  logic                     result,
  output pred_cmp_pkg::pwrite_s    wr
);
  import pred_cmp_pkg::*;

  always_comb begin
    wr = '0;
    if (go) begin
      unique case (ctype)
        CT_NORM: if (qp_val) wr = '{en1: 1'b1, val1: result, en2: 1'b1, val2: !result};
        CT_UNC:  wr = '{en1: 1'b1, val1: qp_val && result,
                        en2: 1'b1, val2: qp_val && !result};
        CT_AND:  if (qp_val && !result) wr = '{en1: 1'b1, val1: 1'b0, en2: 1'b1, val2: 1'b0};
        CT_OR:   if (qp_val && result)  wr = '{en1: 1'b1, val1: 1'b1, en2: 1'b1, val2: 1'b1};
        default: wr = '0;
      endcase
    end
  end
endmodule

// File: rtl/pred_file.sv
module pred_file #(
  parameter int NUM_PRED  = 64,
  parameter int NUM_GUARD = 2,
  localparam int IW = $clog2(NUM_PRED)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  pred_cmp_pkg::pwrite_s   wr,
  input  logic [IW-1:0]           idx1,
  input  logic [IW-1:0]           idx2,
  input  logic [IW-1:0]           qp_idx,
  output logic                    qp_val,
  input  logic [NUM_GUARD*IW-1:0] guard_idx,
  output logic [NUM_GUARD-1:0]    guard_bit,
  output logic [NUM_PRED-1:0]     snapshot
);
  logic [NUM_PRED-1:0] file_q, file_d;
  logic                wr_any;

  assign wr_any = wr.en1 || wr.en2;

  always_comb begin
    file_d = file_q;
    if (wr.en1) file_d[idx1] = wr.val1;
    if (wr.en2) file_d[idx2] = wr.val2;
    file_d[0] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      file_q <= {{(NUM_PRED-1){1'b0}}, 1'b1};
    else if (wr_any) file_q <= file_d;
  end

  assign qp_val   = file_q[qp_idx];
  assign snapshot = file_q;

  for (genvar g = 0; g < NUM_GUARD; g++) begin : g_guard
    assign guard_bit[g] = file_q[guard_idx[g*IW +: IW]];
  end
endmodule

// File: rtl/pred_cmp_unit.sv
module pred_cmp_unit #(
  parameter int DATA_W    = 64,
  parameter int NUM_PRED  = 64,
  parameter int NUM_GUARD = 2,
  localparam int IW = $clog2(NUM_PRED)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [DATA_W-1:0]       req_opa,
  input  logic [DATA_W-1:0]       req_opb,
  input  logic [3:0]              req_test,
  input  logic [1:0]              req_ctype,
  input  logic [IW-1:0]           req_dst1,
  input  logic [IW-1:0]           req_dst2,
  input  logic [IW-1:0]           req_qp,
  output logic                    req_illegal,
  input  logic [NUM_GUARD*IW-1:0] guard_idx,
  output logic [NUM_GUARD-1:0]    guard_bit,
  output logic [NUM_PRED-1:0]     pred_snapshot
);
  import pred_cmp_pkg::*;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       result, code_ok, legal, qp_val;
  pwrite_s    wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pred_cmp_eval #(.DATA_W(DATA_W)) u_eval (
    .opa(req_opa), .opb(req_opb), .test(req_test),
    .result(result), .code_ok(code_ok)
  );

  assign legal       = code_ok && (req_dst1 != req_dst2);
  assign req_illegal = req_valid && !legal;

  pred_cmp_wb u_wb (
    .go(req_valid && legal), .ctype(req_ctype), .qp_val(qp_val),
    .result(result), .wr(wr)
  );

  pred_file #(.NUM_PRED(NUM_PRED), .NUM_GUARD(NUM_GUARD)) u_file (
    .clk(clk), .rst_n(rst_int_n), .wr(wr),
    .idx1(req_dst1), .idx2(req_dst2),
    .qp_idx(req_qp), .qp_val(qp_val),
    .guard_idx(guard_idx), .guard_bit(guard_bit),
    .snapshot(pred_snapshot)
  );
endmodule

// File: rtl/pred_cmp_chk.sv
module pred_cmp_chk #(
  parameter int NUM_PRED  = 64,
  parameter int NUM_GUARD = 2,
  localparam int IW = $clog2(NUM_PRED)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_valid,
  input logic [1:0]              req_ctype,
  input logic [IW-1:0]           req_dst1,
  input logic [IW-1:0]           req_dst2,
  input logic [IW-1:0]           req_qp,
  input logic                    req_illegal,
  input logic [NUM_GUARD*IW-1:0] guard_idx,
  input logic [NUM_GUARD-1:0]    guard_bit,
  input logic [NUM_PRED-1:0]     pred_snapshot
);
  assert_flag0_true_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pred_snapshot[0]);

  assert_illegal_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_illegal) |=> $stable(pred_snapshot));

  assert_idle_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(pred_snapshot));

  assert_norm_complement_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_illegal && req_ctype == 2'd0 && pred_snapshot[req_qp] &&
     req_dst1 != 0 && req_dst2 != 0)
    |=> pred_snapshot[$past(req_dst1)] != pred_snapshot[$past(req_dst2)]);

  assert_unc_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_illegal && req_ctype == 2'd1 && !pred_snapshot[req_qp] &&
     req_dst1 != 0)
    |=> !pred_snapshot[$past(req_dst1)]);

  for (genvar g = 0; g < NUM_GUARD; g++) begin : g_chk
    assert_guard_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
      guard_bit[g] == pred_snapshot[guard_idx[g*IW +: IW]]);
  end
endmodule

bind pred_cmp_unit pred_cmp_chk #(.NUM_PRED(NUM_PRED), .NUM_GUARD(NUM_GUARD)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ctype(req_ctype),
  .req_dst1(req_dst1), .req_dst2(req_dst2), .req_qp(req_qp),
  .req_illegal(req_illegal), .guard_idx(guard_idx), .guard_bit(guard_bit),
  .pred_snapshot(pred_snapshot)
);

// File: tb/pred_cmp_unit_tb_top.sv
module pred_cmp_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] req_opa = '0, req_opb = '0;
  logic [3:0]  req_test = '0;
  logic [1:0]  req_ctype = '0;
  logic [5:0]  req_dst1 = '0, req_dst2 = '0, req_qp = '0;
  logic        req_illegal;
  logic [11:0] guard_idx = '0;
  logic [1:0]  guard_bit;
  logic [63:0] pred_snapshot;

  int          n_chk = 0, n_fail = 0;
  logic [63:0] mdl;
  logic [63:0] exp_q[$];
  string       tag_q[$];
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pred_cmp_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_opa(req_opa),
    .req_opb(req_opb), .req_test(req_test), .req_ctype(req_ctype),
    .req_dst1(req_dst1), .req_dst2(req_dst2), .req_qp(req_qp),
    .req_illegal(req_illegal), .guard_idx(guard_idx), .guard_bit(guard_bit),
    .pred_snapshot(pred_snapshot)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit eval(logic [3:0] t, logic [63:0] a, logic [63:0] b, output bit ok);
    ok = 1;
    case (t)
      0: return a == b;
      1: return a != b;
      2: return $signed(a) <  $signed(b);
      3: return $signed(a) <= $signed(b);
      4: return $signed(a) >  $signed(b);
      5: return $signed(a) >= $signed(b);
      6: return a <  b;
      7: return a <= b;
      8: return a >  b;
      9: return a >= b;
      default: begin ok = 0; return 0; end
    endcase
  endfunction

  // Driver: presents one request, checks the same-cycle illegal flag,
  // updates the model and queues the snapshot due after the next edge.
  task automatic drive(string tag, logic [3:0] t, logic [1:0] ct,
                       logic [63:0] a, logic [63:0] b,
                       logic [5:0] d1, logic [5:0] d2, logic [5:0] qp);
    bit ok, r, q, ill;
    @(negedge clk);
    req_valid = 1; req_test = t; req_ctype = ct; req_opa = a; req_opb = b;
    req_dst1 = d1; req_dst2 = d2; req_qp = qp;
    r   = eval(t, a, b, ok);
    ill = !ok || (d1 == d2);
    q   = mdl[qp];
    #1;
    check({tag, " illegal flag"}, {63'b0, req_illegal}, {63'b0, ill});
    if (!ill) begin
      case (ct)
        2'd0: if (q) begin mdl[d1] = r; mdl[d2] = !r; end
        2'd1: begin mdl[d1] = q && r; mdl[d2] = q && !r; end
        2'd2: if (q && !r) begin mdl[d1] = 0; mdl[d2] = 0; end
        default: if (q && r) begin mdl[d1] = 1; mdl[d2] = 1; end
      endcase
      mdl[0] = 1'b1;
    end
    exp_q.push_back(mdl);
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic guard_chk(string tag, logic [5:0] i0, logic [5:0] i1);
    @(negedge clk);
    req_valid = 0;
    guard_idx = {i1, i0};
    #1;
    check(tag, {62'b0, guard_bit}, {62'b0, mdl[i1], mdl[i0]});
  endtask

  // Monitor: compares the snapshot two time units after each edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        string tg;
        tg = tag_q.pop_front();
        check({tg, " snapshot"}, pred_snapshot, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    mdl = 64'h1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1 reset snapshot", pred_snapshot, 64'h1);
    guard_chk("R10 R2 guard p0 and p5", 6'd0, 6'd5);

    drive("R3 eq true",        4'd0, 2'd0, 64'd5, 64'd5, 6'd1, 6'd2, 6'd0);
    drive("R3 signed lt",      4'd2, 2'd0, -64'sd1, 64'd1, 6'd3, 6'd4, 6'd0);
    drive("R3 unsigned lt",    4'd6, 2'd0, -64'sd1, 64'd1, 6'd5, 6'd6, 6'd0);
    drive("R3 signed ge",      4'd5, 2'd0, 64'd7, 64'd7, 6'd7, 6'd8, 6'd0);
    drive("R3 unsigned gt",    4'd8, 2'd0, 64'd9, 64'd3, 6'd9, 6'd10, 6'd0);
    drive("R3 ne false",       4'd1, 2'd0, 64'd4, 64'd4, 6'd11, 6'd12, 6'd0);
    drive("R3 signed le",      4'd3, 2'd0, 64'd2, -64'sd2, 6'd13, 6'd14, 6'd0);
    drive("R3 signed gt",      4'd4, 2'd0, 64'd2, -64'sd2, 6'd15, 6'd16, 6'd0);
    drive("R3 unsigned le",    4'd7, 2'd0, 64'd2, 64'd2, 6'd17, 6'd18, 6'd0);
    drive("R3 unsigned ge",    4'd9, 2'd0, 64'd1, 64'd2, 6'd19, 6'd20, 6'd0);
    drive("R2 dst p0 ignored", 4'd1, 2'd0, 64'd1, 64'd1, 6'd0, 6'd21, 6'd0);
    idle();
    guard_chk("R10 guard p1 p2", 6'd1, 6'd2);

    // p2 is 0: normal with false qp must not write
    drive("R5 normal qp false", 4'd0, 2'd0, 64'd1, 64'd1, 6'd30, 6'd31, 6'd2);
    drive("R5 and qp false",    4'd1, 2'd2, 64'd1, 64'd1, 6'd1, 6'd9, 6'd2);
    // p1 is 1: unconditional true qp behaves as normal
    drive("R4 unc qp true",     4'd0, 2'd1, 64'd1, 64'd1, 6'd32, 6'd33, 6'd1);
    drive("R4 unc qp false",    4'd0, 2'd1, 64'd1, 64'd1, 6'd32, 6'd21, 6'd2);
    drive("R7 or true",         4'd0, 2'd3, 64'd3, 64'd3, 6'd40, 6'd41, 6'd1);
    drive("R7 or false",        4'd1, 2'd3, 64'd3, 64'd3, 6'd42, 6'd40, 6'd1);
    drive("R6 and true",        4'd0, 2'd2, 64'd3, 64'd3, 6'd40, 6'd41, 6'd1);
    drive("R6 and false",       4'd1, 2'd2, 64'd3, 64'd3, 6'd40, 6'd41, 6'd1);
    drive("R8 same dst",        4'd0, 2'd0, 64'd3, 64'd3, 6'd50, 6'd50, 6'd0);
    drive("R9 bad test code",   4'd12, 2'd0, 64'd3, 64'd3, 6'd50, 6'd51, 6'd0);
    // R11: second request's qp (p60) is written by the first, one edge earlier
    drive("R11 first",          4'd0, 2'd0, 64'd8, 64'd8, 6'd60, 6'd61, 6'd0);
    drive("R11 second",         4'd0, 2'd0, 64'd8, 64'd8, 6'd62, 6'd63, 6'd60);
    drive("R11 third qp false", 4'd0, 2'd0, 64'd8, 64'd8, 6'd44, 6'd45, 6'd61);
    idle();
    guard_chk("R10 guard p62 p63", 6'd62, 6'd63);
    guard_chk("R10 guard p40 p32", 6'd40, 6'd32);
    repeat (3) @(negedge clk);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule